// File: doc/BRIEF.md
# Sequential BCD to Binary Converter

This block turns an unsigned packed-BCD number of `DIGITS` decimal digits into a plain binary value. It does so serially by running the shift-and-correct (double-dabble) method backwards. The whole BCD/binary register moves one bit to the right on each clock. After each shift, any BCD digit that holds 8 or more is reduced by 3. After as many steps as the binary result has bits, the binary half holds the converted value.

A client presents the BCD word together with a one-cycle start strobe while the block is idle. The block then reports busy. A fixed number of cycles later it raises done for one cycle, and the result appears on the binary output. The result stays there until the next done pulse. A start that arrives while the block is busy is dropped. If any input digit is above 9, a flag rises together with done. In that case the binary value carries no meaning.

Top module: `bcd_to_bin_seq`

## Requirements
- R1: After a synchronous reset (active high), `done_o`, `busy_o` and `bad_o` are 0 and `bin_o` is all zeros.
- R2: Digit k of `bcd_i` sits in bits 4k+3..4k, with the least significant decimal digit in bits 3..0. For valid digits, `bin_o` at the done pulse equals the sum over k of digit_k·10^k. `bin_o` is $clog2(10^DIGITS) bits wide, which is 10 bits for the default of 3 digits.
- R3: With `BIN_W` result bits, `done_o` is high in exactly one cycle per accepted start. That cycle is the BIN_W+3rd cycle, counting the cycle in which the accepted start is high as the first. In all cycles before it, `done_o` is low.
- R4: `busy_o` is high from the cycle after an accepted start up to, but not including, the done cycle. It is low in the done cycle.
- R5: A start strobe while `busy_o` is high has no effect. The running conversion keeps its operand and its timing, and no extra done pulse follows.
- R6: A start strobe while `busy_o` is low is accepted, including one given in the done cycle of the previous conversion. The new conversion then keeps the R3 timing.
- R7: `bad_o` is high in the done cycle if any input digit was above 9, and low in that cycle otherwise. `bad_o` is never high outside a done cycle.
- R8: `bin_o` changes only in a done cycle and otherwise holds the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe, sampled when idle |
| bcd_i | input | 4*DIGITS | Packed BCD operand |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| bad_o | output | 1 | Some input digit was above 9 (valid with done) |
| bin_o | output | BIN_W | Binary result |

## Verification
The operands are chosen to separate failure modes:
- Zero and 1 expose an off-by-one in the shift count.
- 999 drives every digit through the subtract-3 correction on many steps.
- 512 and 100 carry a value across digit boundaries.
- 90 leaves a zero digit below a large one.

Two invalid operands check the flag: one has a bad middle digit and one a bad top digit. The fixed latency is checked by sampling done one cycle before, in, and one cycle after the expected cycle. A start in the middle of a run carries a different operand and must leave the result unchanged. A start given in the done cycle must launch a second, correctly timed conversion.

// File: rtl/bcd2bin_pkg.sv
package bcd2bin_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } conv_state_e;

endpackage

// File: rtl/bcd_digit_fix.sv
module bcd_digit_fix (
    input  logic [3:0] nib_i,
    output logic [3:0] nib_o
);
    always_comb begin
        if (nib_i >= 4'd8) nib_o = nib_i - 4'd3;
        else               nib_o = nib_i;
    end
endmodule

// File: rtl/bcd_digit_check.sv
module bcd_digit_check #(
    parameter int DIGITS = 3
) (
    input  logic [4*DIGITS-1:0] bcd_i,
    output logic                all_ok_o
);
    logic [DIGITS-1:0] ok_vec;

    for (genvar k = 0; k < DIGITS; k++) begin : g_dig
        assign ok_vec[k] = (bcd_i[4*k +: 4] <= 4'd9);
    end

    assign all_ok_o = &ok_vec;
endmodule

// File: rtl/bcd_rev_step.sv
module bcd_rev_step #(
    parameter int DIGITS = 3,
    parameter int BIN_W  = 10
) (
    input  logic [4*DIGITS-1:0] bcd_i,
    input  logic [BIN_W-1:0]    bin_i,
    output logic [4*DIGITS-1:0] bcd_o,
    output logic [BIN_W-1:0]    bin_o
);
    localparam int BCD_W = 4 * DIGITS;
    localparam int CAT_W = BCD_W + BIN_W;

    logic [CAT_W-1:0] shifted;
    logic [BCD_W-1:0] bcd_sh;

    assign shifted = {bcd_i, bin_i} >> 1;
    assign bcd_sh  = shifted[CAT_W-1:BIN_W];
    assign bin_o   = shifted[BIN_W-1:0];

    for (genvar k = 0; k < DIGITS; k++) begin : g_fix
        bcd_digit_fix u_fix (
            .nib_i (bcd_sh[4*k +: 4]),
            .nib_o (bcd_o[4*k +: 4])
        );
    end
endmodule

// File: rtl/bcd_to_bin_seq.sv
module bcd_to_bin_seq #(
    parameter  int DIGITS = 3,
    localparam int BIN_W  = $clog2(10 ** DIGITS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [4*DIGITS-1:0] bcd_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                bad_o,
    output logic [BIN_W-1:0]    bin_o
);
    import bcd2bin_pkg::*;

    localparam int BCD_W = 4 * DIGITS;
    localparam int CNT_W = (BIN_W > 1) ? $clog2(BIN_W) : 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(BIN_W - 1);

    typedef struct packed {
        conv_state_e      state;
        logic [CNT_W-1:0] cnt;
        logic [BCD_W-1:0] work_bcd;
        logic [BIN_W-1:0] work_bin;
        logic             bad;
        logic             done;
        logic             bad_out;
        logic [BIN_W-1:0] result;
    } conv_regs_t;

    conv_regs_t r_d, r_q;

    logic             in_ok;
    logic             work_ok;
    logic [BCD_W-1:0] step_bcd;
    logic [BIN_W-1:0] step_bin;

    bcd_digit_check #(.DIGITS(DIGITS)) u_in_chk (
        .bcd_i    (bcd_i),
        .all_ok_o (in_ok)
    );

    bcd_digit_check #(.DIGITS(DIGITS)) u_work_chk (
        .bcd_i    (r_q.work_bcd),
        .all_ok_o (work_ok)
    );

    bcd_rev_step #(.DIGITS(DIGITS), .BIN_W(BIN_W)) u_step (
        .bcd_i (r_q.work_bcd),
        .bin_i (r_q.work_bin),
        .bcd_o (step_bcd),
        .bin_o (step_bin)
    );

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.bad_out = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.work_bcd = bcd_i;
                    r_d.work_bin = '0;
                    r_d.bad      = ~in_ok;
                    r_d.cnt      = '0;
                    r_d.state    = ST_RUN;
                end
            end
            ST_RUN: begin
                r_d.work_bcd = step_bcd;
                r_d.work_bin = step_bin;
                r_d.cnt      = r_q.cnt + 1'b1;
                if (r_q.cnt == LAST_STEP) r_d.state = ST_FIN;
            end
            ST_FIN: begin
                r_d.result  = r_q.work_bin;
                r_d.bad_out = r_q.bad;
                r_d.done    = 1'b1;
                r_d.state   = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o = (r_q.state != ST_IDLE);
    assign done_o = r_q.done;
    assign bad_o  = r_q.bad_out;
    assign bin_o  = r_q.result;

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R6
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    // R3
    step_count_chk: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_RUN && r_q.cnt != LAST_STEP)
            |=> (r_q.cnt == CNT_W'($past(r_q.cnt) + 1'b1)));

    // R2
    digit_range_chk: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_RUN && !r_q.bad) |-> work_ok);

    // R7
    bad_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        bad_o |-> done_o);

    // R8
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(bin_o) |-> done_o);

endmodule

// File: tb/sim_bcd_to_bin_seq.sv
module sim_bcd_to_bin_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DIGITS     = 3;
    localparam int BIN_W      = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [4*DIGITS-1:0] bcd_i = '0;
    logic              busy_o, done_o, bad_o;
    logic [BIN_W-1:0]  bin_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    bcd_to_bin_seq #(.DIGITS(DIGITS)) u0 (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .bcd_i   (bcd_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .bad_o   (bad_o),
        .bin_o   (bin_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int bcd_value(input logic [4*DIGITS-1:0] b);
        int v = 0;
        for (int k = DIGITS - 1; k >= 0; k--) v = v * 10 + int'(b[4*k +: 4]);
        return v;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // One conversion; optional poke with a second start mid-run (R5)
    task automatic run_conv(input logic [4*DIGITS-1:0] b, input int exp_val,
                            input bit exp_bad, input bit poke);
        @(negedge clk);
        start_i = 1'b1; bcd_i = b;
        @(negedge clk);
        start_i = 1'b0;
        check("R4 busy after start", int'(busy_o), 1);
        for (int i = 1; i <= BIN_W; i++) begin
            if (poke && i == 3) begin start_i = 1'b1; bcd_i = 12'h999; end
            @(negedge clk);
            start_i = 1'b0;
            if (done_o || !busy_o) begin
                check("R3 done early / R4 busy", int'(done_o), 0);
                check("R4 busy during run", int'(busy_o), 1);
            end
        end
        @(negedge clk);
        check("R3 done in cycle BIN_W+3", int'(done_o), 1);
        check("R4 busy low at done", int'(busy_o), 0);
        check("R7 bad flag", int'(bad_o), int'(exp_bad));
        if (!exp_bad) check("R2 result value", int'(bin_o), exp_val);
        @(negedge clk);
        check("R3 done single cycle", int'(done_o), 0);
        check("R7 bad only with done", int'(bad_o), 0);
        if (!exp_bad) check("R8 result held", int'(bin_o), exp_val);
        if (poke) begin
            for (int i = 0; i < BIN_W + 4; i++) begin
                @(negedge clk);
                if (done_o) check("R5 no extra done", int'(done_o), 0);
            end
            check("R5 result kept", int'(bin_o), exp_val);
        end
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 done after reset", int'(done_o), 0);
        check("R1 busy after reset", int'(busy_o), 0);
        check("R1 bad after reset", int'(bad_o), 0);
        check("R1 result after reset", int'(bin_o), 0);
        rst = 1'b0;
    endtask

    // R6: start given in the done cycle of the previous conversion
    task automatic test_back_to_back();
        @(negedge clk);
        start_i = 1'b1; bcd_i = 12'h246;
        @(negedge clk);
        start_i = 1'b0;
        repeat (BIN_W) @(negedge clk);
        @(negedge clk);
        check("R6 first done", int'(done_o), 1);
        check("R6 first value", int'(bin_o), 246);
        start_i = 1'b1; bcd_i = 12'h813;
        @(negedge clk);
        start_i = 1'b0;
        check("R6 second accepted", int'(busy_o), 1);
        for (int i = 1; i <= BIN_W; i++) begin
            @(negedge clk);
            if (done_o) check("R6 done early", int'(done_o), 0);
        end
        check("R8 old result held during run", int'(bin_o), 246);
        @(negedge clk);
        check("R6 second done", int'(done_o), 1);
        check("R6 second value", int'(bin_o), 813);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        test_reset();
        run_conv(12'h000, 0, 1'b0, 1'b0);
        run_conv(12'h001, 1, 1'b0, 1'b0);
        run_conv(12'h999, bcd_value(12'h999), 1'b0, 1'b0);
        run_conv(12'h512, 512, 1'b0, 1'b0);
        run_conv(12'h100, 100, 1'b0, 1'b0);
        run_conv(12'h090, 90, 1'b0, 1'b0);
        run_conv(12'h0A5, 0, 1'b1, 1'b0);
        run_conv(12'hF00, 0, 1'b1, 1'b0);
        run_conv(12'h037, 37, 1'b0, 1'b1);
        test_back_to_back();
        report();
    end
endmodule